// File: doc/BRIEF.md
# Prescaled UART Baud Tick Generator

This block produces the enable pulse that paces a UART's transmit and receive shift logic at sixteen times the bit rate. The pulse comes from one of four sources. The internal clock or an external serial clock can drive it directly. Either clock can also go through a two-stage generator. The first stage is a prescaler that divides by 1, 4, 16 or 64. The second stage is an 8-bit divisor counter.

The internal base clock is the system clock divided by two. This makes the fastest internal bit rate the system clock over 32. The external serial clock is brought into the system clock domain by a synchronizer, and each of its rising edges counts as one base event. A write strobe on the baud setting restarts both counters, so a new rate begins cleanly from a known phase.

The surrounding register file drives the line-control and baud fields, so the block sees them as plain inputs. The consumers of the tick are outside this block.

Top module: `baud_tick_gen`

## Requirements
- R1: The baud setting `baud_cfg` carries the divisor in bits 7:0 and the prescale select in bits 9:8. Select values 0, 1, 2 and 3 divide the base events by 1, 4, 16 and 64 ahead of the divisor stage.
- R2: In a generator mode, one tick is issued for every `prescale * divisor` base events. With the internal source this is a tick period of `2 * prescale * divisor` system clock cycles.
- R3: A divisor of 0 behaves exactly like a divisor of 1.
- R4: `clk_src` selects the source: 0 = internal direct, 1 = internal through the generator, 2 = external direct, 3 = external through the generator. With an external source selected and no external edges, no tick is issued.
- R5: Internal direct mode ticks on every second system clock cycle, which makes the bit rate the system clock divided by 32.
- R6: The external clock passes through a two-flop synchronizer followed by a rising-edge detector. Each rising edge counts as exactly one base event. In external direct mode, the tick appears in the third cycle after the edge is sampled.
- R7: A tick is one system clock cycle wide. Two ticks never fall in consecutive cycles while `clk_src` is held.
- R8: A cycle with `cfg_wr` high restarts the prescaler, the divisor counter and the internal half-rate phase, using the `baud_cfg` value presented in that cycle. No generated tick is issued in that cycle, and a base event arriving in that cycle is discarded. The first tick after the restart comes a full period later, in cycle `2 * prescale * divisor` with the internal source.
- R9: The slowest setting is divisor 0xFF with prescale 64. With the internal source this gives a tick period of 32640 cycles.
- R10: While reset is held, tick is low. After reset is released in internal direct mode, the first tick appears in the first cycle after the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_src | input | 2 | Tick source select (R4 encoding) |
| baud_cfg | input | 10 | Prescale select [9:8] and divisor [7:0] |
| cfg_wr | input | 1 | Restart strobe for the baud setting |
| ext_clk | input | 1 | Asynchronous external serial clock |
| tick | output | 1 | One-cycle enable pulse at 16x the bit rate |

## Verification
A restart strobe and a base event can land in the same cycle. The case that matters is an external edge whose synchronized pulse reaches the counters on the very edge that takes `cfg_wr`. The bench provokes this by raising `ext_clk` two negative edges before it asserts `cfg_wr`, so the two arrive together. It then counts the ticks produced by a known number of later edges; with a divisor of 2, one tick means the coinciding edge was discarded and two means it leaked through. The same collision is applied on the internal path by asserting `cfg_wr` in the cycle where a tick is showing, and the bench then expects a full period of silence.

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen #(
  parameter int DIV_W    = 8,
  parameter int PSEL_W   = 2,
  parameter int PRE_STEP = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              clk_src,
  input  logic [DIV_W+PSEL_W-1:0] baud_cfg,
  input  logic                    cfg_wr,
  input  logic                    ext_clk,
  output logic                    tick
);
  localparam int CFG_W = DIV_W + PSEL_W;
  localparam int PRE_W = PRE_STEP * ((1 << PSEL_W) - 1);

  logic [2:0]        ext_sync;
  logic              ext_edge;
  logic              half;
  logic              base_en;
  logic [PSEL_W-1:0] psel;
  logic [DIV_W-1:0]  div;
  logic [DIV_W-1:0]  div_last;
  logic [PRE_W:0]    pre_full;
  logic [PRE_W-1:0]  pre_lim;
  logic [PRE_W-1:0]  pcnt;
  logic [DIV_W-1:0]  dcnt;
  logic              pre_end;
  logic              gen_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[1:0], ext_clk};
  end

  assign ext_edge = ext_sync[1] & ~ext_sync[2];

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_wr) half <= 1'b0;
    else                  half <= ~half;
  end

  assign base_en  = clk_src[1] ? ext_edge : half;
  assign psel     = baud_cfg[CFG_W-1:DIV_W];
  assign div      = baud_cfg[DIV_W-1:0];
  assign div_last = (div == '0) ? '0 : DIV_W'(div - DIV_W'(1));
  assign pre_full = (PRE_W+1)'(1) << (PRE_STEP * psel);
  assign pre_lim  = PRE_W'(pre_full - (PRE_W+1)'(1));
  assign pre_end  = base_en && (pcnt == pre_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (cfg_wr) begin
      pcnt <= '0;
      dcnt <= div_last;
    end else if (base_en) begin
      if (pcnt == pre_lim) begin
        pcnt <= '0;
        dcnt <= (dcnt == '0) ? div_last : DIV_W'(dcnt - DIV_W'(1));
      end else begin
        pcnt <= PRE_W'(pcnt + PRE_W'(1));
      end
    end
  end

  assign gen_tick = pre_end && (dcnt == '0) && !cfg_wr;
  assign tick     = clk_src[0] ? gen_tick : base_en;
endmodule

// File: rtl/baud_tick_gen_chk.sv
`timescale 1ns/1ps
module baud_tick_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] clk_src,
  input logic       cfg_wr,
  input logic       ext_clk,
  input logic       tick
);
  logic [1:0] armed;

  always_ff @(posedge clk) begin
    if (!rst_n)            armed <= '0;
    else if (armed != 2'd3) armed <= armed + 2'd1;
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg_wr) |=> (!tick || clk_src != $past(clk_src))); // R7

  AST_RESTART_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && clk_src[0]) |-> !tick); // R8

  AST_INT_DIRECT_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed != 2'd0 && clk_src == 2'd0 && $past(clk_src) == 2'd0 && !$past(cfg_wr))
    |-> (tick != $past(tick))); // R5

  AST_EXT_EDGE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed == 2'd3 && clk_src == 2'd2)
    |-> (tick == ($past(ext_clk, 2) && !$past(ext_clk, 3)))); // R6
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (.*);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clk_src = 2'd0;
  logic [9:0] baud_cfg = '0;
  logic       cfg_wr = 1'b0;
  logic       ext_clk = 1'b0;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int tc = 0;
  localparam int LIM = 70000;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .clk_src(clk_src), .baud_cfg(baud_cfg),
    .cfg_wr(cfg_wr), .ext_clk(ext_clk), .tick(tick)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic restart(input logic [1:0] src, input logic [1:0] ps, input logic [7:0] dv);
    @(negedge clk);
    clk_src  = src;
    baud_cfg = {ps, dv};
    cfg_wr   = 1'b1;
    @(negedge clk);
    cfg_wr   = 1'b0;
  endtask

  task automatic wait_tick(output int n);
    n = 1;
    while (!tick && n < LIM) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (tick) tc++;
  endtask

  task automatic ext_pulse();
    ext_clk = 1'b1;
    repeat (4) step();
    ext_clk = 1'b0;
    repeat (4) step();
  endtask

  initial begin
    #1_900_000;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    errors++;
    checks++;
    summary();
    $finish;
  end

  initial begin
    int n;
    int m;
    int p;
    int dvs[6] = '{0, 1, 2, 3, 7, 13};

    repeat (3) @(negedge clk);
    chk("R10 tick low during reset", int'(tick), 0);
    rst_n = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      chk("R5 R10 internal direct alternation", int'(tick), i % 2);
    end

    for (int ps = 0; ps < 4; ps++) begin
      for (int k = 0; k < 6; k++) begin
        p = (1 << (2 * ps)) * ((dvs[k] == 0) ? 1 : dvs[k]);
        restart(2'd1, 2'(ps), 8'(dvs[k]));
        wait_tick(n);
        chk((dvs[k] == 0) ? "R3 divisor zero first tick" : "R1 R2 first tick after restart", n, 2 * p);
        @(negedge clk);
        chk("R7 tick one cycle wide", int'(tick), 0);
        wait_tick(m);
        chk("R2 tick period", m, 2 * p);
      end
    end

    restart(2'd1, 2'd0, 8'hFF);
    wait_tick(n);
    chk("R1 divisor 0xFF prescale 1", n, 510);
    restart(2'd1, 2'd3, 8'hFF);
    wait_tick(n);
    chk("R9 slowest setting period", n, 32640);

    restart(2'd1, 2'd0, 8'd5);
    wait_tick(n);
    repeat (3) @(negedge clk);
    restart(2'd1, 2'd0, 8'd5);
    wait_tick(n);
    chk("R8 restart mid period", n, 10);

    restart(2'd1, 2'd0, 8'd2);
    wait_tick(n);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R8 no tick right after restart", int'(tick), 0);
    wait_tick(n);
    chk("R8 restart on tick cycle full period", n, 4);

    restart(2'd2, 2'd0, 8'd3);
    tc = 0;
    repeat (20) step();
    chk("R4 external direct ignores internal clock", tc, 0);
    tc = 0;
    for (int i = 0; i < 5; i++) ext_pulse();
    repeat (6) step();
    chk("R6 one tick per external edge", tc, 5);

    restart(2'd3, 2'd1, 8'd1);
    tc = 0;
    repeat (20) step();
    chk("R4 external generator ignores internal clock", tc, 0);
    for (int i = 0; i < 9; i++) ext_pulse();
    repeat (6) step();
    chk("R6 R1 external prescale by 4", tc, 2);

    restart(2'd3, 2'd0, 8'd3);
    tc = 0;
    for (int i = 0; i < 7; i++) ext_pulse();
    repeat (6) step();
    chk("R6 R2 external divisor 3", tc, 2);

    restart(2'd3, 2'd0, 8'd2);
    repeat (4) step();
    step();
    ext_clk = 1'b1;
    step();
    step();
    cfg_wr = 1'b1;
    tc = 0;
    step();
    cfg_wr = 1'b0;
    repeat (2) step();
    ext_clk = 1'b0;
    repeat (4) step();
    for (int i = 0; i < 3; i++) ext_pulse();
    repeat (6) step();
    chk("R8 edge in restart cycle discarded", tc, 1);

    summary();
    $finish;
  end
endmodule